// File: doc/BRIEF.md
# PLL Reconfiguration Scan Controller

This block keeps a local cache of the counter settings of a phase-locked loop. It shifts that cache, one bit at a time, into the loop's reconfiguration scan chain. On the user side there are three request strobes (read, write, reconfigure), a counter select, a field select, a 9-bit write value and a 9-bit readback bus. A busy flag turns away new requests while an operation is running.

On the PLL side the block drives the following:

- a scan clock at half the system clock rate;
- a scan clock enable;
- a serial data bit;
- a one-cycle configuration-update strobe;
- an active-high PLL reset.

It also watches a scan-done input that comes back from the PLL.

A write or a read only touches the cache. Only a reconfigure request streams the whole cache to the PLL. After the stream ends, the block pulses the update strobe and waits for scan-done. It then pulses the PLL reset and releases it before it drops busy.

The state machine has these states:

| State | What it does |
|---|---|
| IDLE | Waits for a request. |
| READ | Holds busy for a one-cycle read. |
| WRITE | Holds busy for a one-cycle write. |
| ALIGN | Waits for the scan clock to be high, so that the scan can start on its falling edge. |
| SHIFT | Streams the cache while the enable is high. |
| UPDATE | Drives the one-cycle update strobe. |
| WAIT_DONE | Waits for scan-done. |
| RST_PULSE | Holds the PLL reset high. |
| RST_RELEASE | Holds busy for one cycle with the PLL reset low. |

The transitions are:

- IDLE goes to ALIGN on a reconfigure request, to WRITE on a write request, and to READ on a read request.
- READ and WRITE return to IDLE.
- ALIGN goes to SHIFT when the scan clock is high. This edge also loads the chain.
- SHIFT goes to UPDATE on a scan-clock-high cycle once the last bit has been presented.
- UPDATE goes to WAIT_DONE.
- WAIT_DONE goes to RST_PULSE when scan-done is high.
- RST_PULSE goes to RST_RELEASE.
- RST_RELEASE goes to IDLE.

Top module: `pll_scan_ctrl`

## Requirements
- R1: While the block reset is low and right after it, busy, scan_clk_en, cfg_upd and rdata are all 0, and every cached field reads back as 0.
- R2: Counter codes 0 to 7 select one of eight counters. Field codes select as follows: 0 is the high count (8 bits), 1 is the low count (8 bits), 2 is the bypass flag (1 bit), 3 is the odd-division flag (1 bit). A write stores the low bits of wdata that the field needs. A read puts the field on rdata, zero-extended, and rdata is valid in the cycle busy drops.
- R3: Busy is high in the cycle after an accepted request. For a read or a write it is high for exactly one cycle. Any request that arrives while busy is high is dropped.
- R4: When strobes arrive together, reconfigure wins over write and write wins over read. The losing strobes have no effect.
- R5: A request with counter code 8 to 15 or field code 4 to 7 still raises busy for one cycle. Such a write changes no cached field, and such a read leaves rdata unchanged.
- R6: A reconfiguration shifts 144 bits onto scan_dat, MSB first. Counter 0 goes first. Each counter sends high count [7:0], then low count [7:0], then bypass, then odd. One bit is sent per rising scan_clk edge while scan_clk_en is high.
- R7: scan_clk toggles on every system clock. scan_clk_en and scan_dat change only on a falling scan_clk edge, so the enable rises before the first rising edge that samples and falls on the falling edge after the last sampled bit.
- R8: cfg_upd pulses high for exactly one cycle after scan_clk_en has dropped. It pulses once per reconfiguration.
- R9: The PLL reset rises one clock after scan-done is sampled high and stays high for one cycle. Busy stays high for one more cycle with the reset low, then drops.
- R10: pll_rst is high whenever pll_rst_req is high, regardless of state.
- R11: A read or a write never raises scan_clk_en or cfg_upd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low block reset |
| rd_req | input | 1 | Read request strobe |
| wr_req | input | 1 | Write request strobe |
| cfg_req | input | 1 | Reconfigure request strobe |
| cnt_sel | input | 4 | Counter select code |
| fld_sel | input | 3 | Field select code |
| wdata | input | 9 | Write value |
| rdata | output | 9 | Readback value |
| busy | output | 1 | Operation in progress |
| pll_rst_req | input | 1 | External PLL reset request |
| scan_done | input | 1 | Scan-done from the PLL |
| scan_clk | output | 1 | Scan clock (system clock / 2) |
| scan_clk_en | output | 1 | Scan clock enable |
| scan_dat | output | 1 | Serial scan data |
| cfg_upd | output | 1 | Configuration-update strobe |
| pll_rst | output | 1 | Active-high PLL reset |

## Verification
The cache is driven with a table of writes and reads across every field width. It uses values whose upper bits must be cut off, which separates correct field truncation from a plain copy. The reads of reserved counter and field codes, placed between valid ones, separate a true no-op from a read that clears or overwrites rdata. The stream is compared bit for bit against a chain built from a model of the cache, which exposes any error in segment order or bit order. Combined strobes, and a write sent in the middle of a scan, tell the priority rule and the busy lockout apart from a plain first-come rule.

// File: rtl/pll_scan_pkg.sv
package pll_scan_pkg;

    // Field select codes
    localparam logic [2:0] FLD_HI  = 3'd0;
    localparam logic [2:0] FLD_LO  = 3'd1;
    localparam logic [2:0] FLD_BYP = 3'd2;
    localparam logic [2:0] FLD_ODD = 3'd3;

    typedef enum logic [3:0] {
        S_IDLE,
        S_READ,
        S_WRITE,
        S_ALIGN,
        S_SHIFT,
        S_UPDATE,
        S_WAIT_DONE,
        S_RST_PULSE,
        S_RST_RELEASE
    } scan_state_e;

endpackage

// File: rtl/pll_scan_cache.sv
module pll_scan_cache
    import pll_scan_pkg::*;
#(
    parameter int NUM_CNT   = 8,
    parameter int CNT_W     = 8,
    parameter int TSEL_W    = 4,
    parameter int PSEL_W    = 3,
    parameter int DATA_W    = 9,
    parameter int SEG_W     = 2 * CNT_W + 2,
    parameter int CHAIN_LEN = NUM_CNT * SEG_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [TSEL_W-1:0]    tsel,
    input  logic [PSEL_W-1:0]    psel,
    input  logic [DATA_W-1:0]    wdata,
    output logic [DATA_W-1:0]    rd_val,
    output logic                 sel_ok,
    output logic [CHAIN_LEN-1:0] chain
);
    localparam int IDX_W = $clog2(NUM_CNT);

    logic [CNT_W-1:0] hi_q  [NUM_CNT];
    logic [CNT_W-1:0] lo_q  [NUM_CNT];
    logic             byp_q [NUM_CNT];
    logic             odd_q [NUM_CNT];
    logic [IDX_W-1:0] idx;

    assign idx    = tsel[IDX_W-1:0];
    assign sel_ok = (int'(tsel) < NUM_CNT) && (psel <= FLD_ODD);

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                hi_q[i]  <= '0;
                lo_q[i]  <= '0;
                byp_q[i] <= 1'b0;
                odd_q[i] <= 1'b0;
            end else if (we && sel_ok && (int'(idx) == i)) begin
                unique case (psel)
                    FLD_HI:  hi_q[i]  <= wdata[CNT_W-1:0];
                    FLD_LO:  lo_q[i]  <= wdata[CNT_W-1:0];
                    FLD_BYP: byp_q[i] <= wdata[0];
                    default: odd_q[i] <= wdata[0];
                endcase
            end
        end

        // counter 0 occupies the most significant segment
        assign chain[CHAIN_LEN-1-i*SEG_W -: SEG_W] = {hi_q[i], lo_q[i], byp_q[i], odd_q[i]};
    end

    always_comb begin
        rd_val = '0;
        case (psel)
            FLD_HI:  rd_val[CNT_W-1:0] = hi_q[idx];
            FLD_LO:  rd_val[CNT_W-1:0] = lo_q[idx];
            FLD_BYP: rd_val[0]         = byp_q[idx];
            FLD_ODD: rd_val[0]         = odd_q[idx];
            default: rd_val            = '0;
        endcase
    end

endmodule

// File: rtl/pll_scan_shifter.sv
module pll_scan_shifter #(
    parameter int CHAIN_LEN = 144
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic                 step,
    input  logic [CHAIN_LEN-1:0] chain_in,
    output logic                 sclk,
    output logic                 sdo,
    output logic                 last
);
    localparam int CW = $clog2(CHAIN_LEN);

    logic [CHAIN_LEN-1:0] sr_q;
    logic [CW-1:0]        cnt_q;
    logic                 ph_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q  <= 1'b0;
            sr_q  <= '0;
            cnt_q <= '0;
        end else begin
            ph_q <= ~ph_q;
            if (load) begin
                sr_q  <= chain_in;
                cnt_q <= '0;
            end else if (step) begin
                sr_q  <= {sr_q[CHAIN_LEN-2:0], 1'b0};
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign sclk = ph_q;
    assign sdo  = sr_q[CHAIN_LEN-1];
    assign last = (cnt_q == CW'(CHAIN_LEN - 1));

endmodule

// File: rtl/pll_scan_ctrl.sv
module pll_scan_ctrl
    import pll_scan_pkg::*;
#(
    parameter int NUM_CNT = 8,
    parameter int CNT_W   = 8,
    parameter int TSEL_W  = 4,
    parameter int PSEL_W  = 3,
    parameter int DATA_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic              wr_req,
    input  logic              cfg_req,
    input  logic [TSEL_W-1:0] cnt_sel,
    input  logic [PSEL_W-1:0] fld_sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              busy,
    input  logic              pll_rst_req,
    input  logic              scan_done,
    output logic              scan_clk,
    output logic              scan_clk_en,
    output logic              scan_dat,
    output logic              cfg_upd,
    output logic              pll_rst
);
    localparam int SEG_W     = 2 * CNT_W + 2;
    localparam int CHAIN_LEN = NUM_CNT * SEG_W;

    scan_state_e          state_q, state_d;
    logic                 take_cfg, take_wr, take_rd;
    logic [DATA_W-1:0]    rd_val;
    logic                 sel_ok;
    logic [CHAIN_LEN-1:0] chain;
    logic                 load, step, last;

    // priority: reconfigure, then write, then read
    assign take_cfg = (state_q == S_IDLE) && cfg_req;
    assign take_wr  = (state_q == S_IDLE) && wr_req && !cfg_req;
    assign take_rd  = (state_q == S_IDLE) && rd_req && !cfg_req && !wr_req;

    assign load = (state_q == S_ALIGN) && scan_clk;
    assign step = (state_q == S_SHIFT) && scan_clk && !last;

    pll_scan_cache #(
        .NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .TSEL_W(TSEL_W),
        .PSEL_W(PSEL_W), .DATA_W(DATA_W), .SEG_W(SEG_W), .CHAIN_LEN(CHAIN_LEN)
    ) u_cache (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (take_wr),
        .tsel   (cnt_sel),
        .psel   (fld_sel),
        .wdata  (wdata),
        .rd_val (rd_val),
        .sel_ok (sel_ok),
        .chain  (chain)
    );

    pll_scan_shifter #(.CHAIN_LEN(CHAIN_LEN)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .step     (step),
        .chain_in (chain),
        .sclk     (scan_clk),
        .sdo      (scan_dat),
        .last     (last)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (take_cfg)     state_d = S_ALIGN;
                else if (take_wr) state_d = S_WRITE;
                else if (take_rd) state_d = S_READ;
            end
            S_READ, S_WRITE: state_d = S_IDLE;
            S_ALIGN:         if (scan_clk) state_d = S_SHIFT;
            S_SHIFT:         if (scan_clk && last) state_d = S_UPDATE;
            S_UPDATE:        state_d = S_WAIT_DONE;
            S_WAIT_DONE:     if (scan_done) state_d = S_RST_PULSE;
            S_RST_PULSE:     state_d = S_RST_RELEASE;
            S_RST_RELEASE:   state_d = S_IDLE;
            default:         state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                rdata <= '0;
        else if (take_rd && sel_ok) rdata <= rd_val;
    end

    always_comb begin
        busy        = (state_q != S_IDLE);
        scan_clk_en = (state_q == S_SHIFT);
        cfg_upd     = (state_q == S_UPDATE);
        pll_rst     = (state_q == S_RST_PULSE) || pll_rst_req;
    end

endmodule

// File: rtl/pll_scan_ctrl_chk.sv
module pll_scan_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic rd_req,
    input logic wr_req,
    input logic cfg_req,
    input logic busy,
    input logic scan_clk,
    input logic scan_clk_en,
    input logic scan_dat,
    input logic cfg_upd,
    input logic pll_rst,
    input logic pll_rst_req
);
    p_busy_after_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && (rd_req || wr_req || cfg_req)) |=> busy);

    p_ext_rst_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pll_rst_req |-> pll_rst);

    p_upd_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_upd |=> !cfg_upd);

    p_upd_no_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_upd |-> !scan_clk_en);

    p_en_moves_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(scan_clk_en) |-> !scan_clk);

    p_dat_held_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_clk_en && $rose(scan_clk)) |-> $stable(scan_dat));

    p_busy_past_rst_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && pll_rst && !pll_rst_req) |=> busy);

    p_sclk_toggle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        scan_clk_en |=> (scan_clk != $past(scan_clk)));

endmodule

bind pll_scan_ctrl pll_scan_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .wr_req(wr_req), .cfg_req(cfg_req),
    .busy(busy), .scan_clk(scan_clk), .scan_clk_en(scan_clk_en), .scan_dat(scan_dat),
    .cfg_upd(cfg_upd), .pll_rst(pll_rst), .pll_rst_req(pll_rst_req)
);

// File: tb/pll_scan_ctrl_tb.sv
module pll_scan_ctrl_tb;
    localparam int LEN  = 144;
    localparam int NVEC = 18;
    localparam logic [1:0] OP_W = 2'd1;
    localparam logic [1:0] OP_R = 2'd2;

    // {op, counter, field, wdata, expected rdata}
    localparam logic [26:0] VEC [NVEC] = '{
        {OP_W, 4'd0,  3'd0, 9'h1A5, 9'h000},
        {OP_R, 4'd0,  3'd0, 9'h000, 9'h0A5},
        {OP_W, 4'd0,  3'd1, 9'h03C, 9'h000},
        {OP_R, 4'd0,  3'd1, 9'h000, 9'h03C},
        {OP_W, 4'd7,  3'd2, 9'h1FF, 9'h000},
        {OP_R, 4'd7,  3'd2, 9'h000, 9'h001},
        {OP_W, 4'd3,  3'd3, 9'h002, 9'h000},
        {OP_R, 4'd3,  3'd3, 9'h000, 9'h000},
        {OP_W, 4'd5,  3'd0, 9'h081, 9'h000},
        {OP_W, 4'd5,  3'd1, 9'h17E, 9'h000},
        {OP_R, 4'd5,  3'd1, 9'h000, 9'h07E},
        {OP_W, 4'd2,  3'd3, 9'h001, 9'h000},
        {OP_R, 4'd2,  3'd3, 9'h000, 9'h001},
        {OP_W, 4'd9,  3'd0, 9'h055, 9'h000},
        {OP_W, 4'd0,  3'd5, 9'h011, 9'h000},
        {OP_R, 4'd0,  3'd0, 9'h000, 9'h0A5},
        {OP_R, 4'd12, 3'd1, 9'h000, 9'h0A5},
        {OP_R, 4'd4,  3'd6, 9'h000, 9'h0A5}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rd_req = 1'b0, wr_req = 1'b0, cfg_req = 1'b0;
    logic [3:0] cnt_sel = '0;
    logic [2:0] fld_sel = '0;
    logic [8:0] wdata = '0;
    logic [8:0] rdata;
    logic busy, scan_clk, scan_clk_en, scan_dat, cfg_upd, pll_rst;
    logic pll_rst_req = 1'b0;
    logic scan_done = 1'b0;

    int errors = 0;
    int checks = 0;

    logic [7:0] m_hi [8];
    logic [7:0] m_lo [8];
    logic       m_byp [8];
    logic       m_odd [8];

    logic [LEN-1:0] cap = '0;
    int ncap = 0;
    int r7_bad = 0;
    logic mon_on = 1'b0;
    logic p_sclk = 1'b0, p_en = 1'b0, p_dat = 1'b0;

    always #5 clk = ~clk;

    pll_scan_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .wr_req(wr_req), .cfg_req(cfg_req),
        .cnt_sel(cnt_sel), .fld_sel(fld_sel), .wdata(wdata), .rdata(rdata), .busy(busy),
        .pll_rst_req(pll_rst_req), .scan_done(scan_done), .scan_clk(scan_clk),
        .scan_clk_en(scan_clk_en), .scan_dat(scan_dat), .cfg_upd(cfg_upd), .pll_rst(pll_rst)
    );

    // behavioural scan-chain stub
    always @(posedge scan_clk) begin
        if (scan_clk_en) begin
            cap  <= {cap[LEN-2:0], scan_dat};
            ncap <= ncap + 1;
        end
    end

    // edge discipline monitor (R7)
    always @(negedge clk) begin
        if (mon_on) begin
            if (scan_clk_en != p_en && scan_clk) r7_bad <= r7_bad + 1;
            if (scan_clk_en && p_en && scan_dat != p_dat && scan_clk) r7_bad <= r7_bad + 1;
            if (scan_clk == p_sclk) r7_bad <= r7_bad + 1;
        end
        p_sclk <= scan_clk;
        p_en   <= scan_clk_en;
        p_dat  <= scan_dat;
    end

    task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [LEN-1:0] exp_chain();
        logic [LEN-1:0] c = '0;
        for (int i = 0; i < 8; i++)
            c = {c[LEN-19:0], m_hi[i], m_lo[i], m_byp[i], m_odd[i]};
        return c;
    endfunction

    task automatic model_write(input logic [3:0] c, input logic [2:0] f, input logic [8:0] d);
        if (c < 4'd8 && f < 3'd4) begin
            case (f)
                3'd0: m_hi[c[2:0]]  = d[7:0];
                3'd1: m_lo[c[2:0]]  = d[7:0];
                3'd2: m_byp[c[2:0]] = d[0];
                default: m_odd[c[2:0]] = d[0];
            endcase
        end
    endtask

    task automatic pulse(input logic r, input logic w, input logic g,
                         input logic [3:0] c, input logic [2:0] f, input logic [8:0] d);
        @(negedge clk);
        rd_req = r; wr_req = w; cfg_req = g;
        cnt_sel = c; fld_sel = f; wdata = d;
        @(negedge clk);
        rd_req = 1'b0; wr_req = 1'b0; cfg_req = 1'b0;
    endtask

    task automatic reconfig(input logic with_wr);
        int n0;
        int guard;
        n0 = ncap;
        pulse(1'b0, with_wr, 1'b1, 4'd1, 3'd0, 9'h0EE);
        chk("R3 busy after reconfigure request", busy, 1);
        repeat (10) @(negedge clk);
        pulse(1'b0, 1'b1, 1'b0, 4'd2, 3'd0, 9'h077);  // dropped while busy
        guard = 0;
        while (!cfg_upd && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        chk("R8 update strobe seen with enable low", {cfg_upd, scan_clk_en}, 2'b10);
        chk("R6 bit count", ncap - n0, LEN);
        chk("R6 scanned chain", cap, exp_chain());
        chk("R7 edge discipline violations", r7_bad, 0);
        @(negedge clk);
        chk("R8 update strobe single cycle", cfg_upd, 0);
        repeat (3) @(negedge clk);
        chk("R9 reset waits for scan-done", {pll_rst, busy}, 2'b01);
        scan_done = 1'b1;
        @(negedge clk);
        chk("R9 reset pulse after scan-done", {pll_rst, busy}, 2'b11);
        scan_done = 1'b0;
        @(negedge clk);
        chk("R9 reset released, still busy", {pll_rst, busy}, 2'b01);
        @(negedge clk);
        chk("R9 busy drops after release", busy, 0);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) begin
            m_hi[i] = '0; m_lo[i] = '0; m_byp[i] = 1'b0; m_odd[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        chk("R1 reset outputs", {busy, scan_clk_en, cfg_upd, rdata}, 12'h000);
        rst_n = 1'b1;
        @(negedge clk);
        mon_on = 1'b1;
        pulse(1'b1, 1'b0, 1'b0, 4'd4, 3'd1, 9'h000);
        @(negedge clk);
        chk("R1 cache cleared at reset", rdata, 9'h000);

        // table walk
        for (int k = 0; k < NVEC; k++) begin
            logic [1:0] op;
            logic [3:0] c;
            logic [2:0] f;
            logic [8:0] d, e;
            string tag;
            {op, c, f, d, e} = VEC[k];
            tag = (c >= 4'd8 || f >= 3'd4) ? "R5" : "R2";
            pulse(op == OP_R, op == OP_W, 1'b0, c, f, d);
            chk("R3 busy one cycle (high)", busy, 1);
            chk("R11 no scan activity", {scan_clk_en, cfg_upd}, 2'b00);
            if (op == OP_W) model_write(c, f, d);
            @(negedge clk);
            chk("R3 busy one cycle (low)", busy, 0);
            if (op == OP_R) chk({tag, " readback"}, rdata, e);
        end

        // priority: write beats read (rdata keeps 0A5)
        pulse(1'b1, 1'b1, 1'b0, 4'd1, 3'd0, 9'h033);
        model_write(4'd1, 3'd0, 9'h033);
        @(negedge clk);
        chk("R4 read loses to write", rdata, 9'h0A5);
        pulse(1'b1, 1'b0, 1'b0, 4'd1, 3'd0, 9'h000);
        @(negedge clk);
        chk("R4 write won", rdata, 9'h033);

        // full reconfiguration, plain, then with a competing write
        reconfig(1'b0);
        reconfig(1'b1);
        pulse(1'b1, 1'b0, 1'b0, 4'd1, 3'd0, 9'h000);
        @(negedge clk);
        chk("R4 write lost to reconfigure", rdata, 9'h033);
        pulse(1'b1, 1'b0, 1'b0, 4'd2, 3'd0, 9'h000);
        @(negedge clk);
        chk("R3 write during busy dropped", rdata, 9'h000);

        // external PLL reset
        pll_rst_req = 1'b1;
        #1;
        chk("R10 external reset passes through", {pll_rst, busy}, 2'b10);
        @(negedge clk);
        chk("R10 external reset held", pll_rst, 1);
        pll_rst_req = 1'b0;
        #1;
        chk("R10 external reset released", pll_rst, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 10);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule